// File: doc/BRIEF.md
# SDR SDRAM Power-Up and Refresh Sequencer

This block owns the control pins of one rank of single-data-rate SDRAM from reset onwards. After reset it drives a long stretch of NOP cycles with the clock enable high. It then precharges every bank, issues a fixed number of auto-refresh commands and programs the mode register for single-beat bursts with a CAS latency of two. When that is done it raises `ready`.

While it is ready, a free-running interval counter schedules periodic refreshes. Each one is a precharge-all, a short NOP gap, an auto-refresh and a longer NOP gap, and `refresh_busy` is high for the whole sequence. A level request, `sr_req`, parks the device in self-refresh with the clock enable low. When the request is released, the block brings the device back out and waits out the exit recovery time.

All waits are given in nanoseconds or microseconds and are converted to clock cycles at elaboration from the `CLK_HZ` parameter. Column and row addressing of data accesses, the data path and bank tracking belong to other blocks. This block has no data stream, so every pin is plain control or status with no handshake. A client may start an access only in a cycle where `ready` is high.

Top module: `sdr_init_refresh_seq`

## Requirements
- R1: After reset the block drives NOP with CKE high, `ready` low and `refresh_busy` low for ceil(INIT_US × f) cycles, where f is `CLK_HZ`. This is 9600 cycles at the default 200 µs and 48 MHz.
- R2: The first command after the power-up wait is PRECHARGE ALL, with address bit 10 set and all other address bits and the bank bits zero. It is followed by tRP NOP cycles.
- R3: Next come eight AUTO REFRESH commands with CKE high, each followed by tRC NOP cycles. Consecutive refresh commands are therefore tRC+1 cycles apart.
- R4: After the last refresh gap the block issues LOAD MODE with address 0x020 and bank 0. In that word, bits [2:0]=000 select burst length 1, bit 3=0 selects sequential order and bits [6:4]=010 select CAS latency 2. Two NOP cycles follow, then `ready` rises. CKE is high whenever `ready` is high.
- R5: Each wait in cycles is ceil(t_ns × f / 1e9), and any result below 2 is raised to 2. At 48 MHz this gives tRP=2, tRC=4 (65 ns), tRAS=3 (45 ns) and tXSR=4 (75 ns).
- R6: The refresh interval is floor(f × 64 ms / 4096) cycles, which is 750 at 48 MHz. The first periodic PRECHARGE ALL comes exactly one interval after `ready` rises. Later ones come one interval after the previous one, counted from the moment normal operation resumed.
- R7: A periodic refresh is PRECHARGE ALL, tRP NOPs, AUTO REFRESH, then tRC NOPs. `refresh_busy` is high and `ready` is low in exactly those cycles.
- R8: When `sr_req` is high while the block is ready, it issues PRECHARGE ALL and waits tRP NOPs. It then issues the self-refresh command: the auto-refresh encoding with CKE low. CKE stays low while the request is held.
- R9: CKE stays low for at least tRAS+1 cycles from the self-refresh command, even if `sr_req` falls earlier.
- R10: On exit, CKE returns high and only NOPs are issued for tXSR cycles. `ready` then rises and the refresh interval restarts from zero.
- R11: If a periodic refresh falls due in the same cycle that `sr_req` is seen, the refresh sequence runs first. The self-refresh entry follows directly after it.
- R12: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as follows: NOP=0111, PRECHARGE=0010, AUTO REFRESH=0001, LOAD MODE=0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, frequency given by `CLK_HZ` |
| rst_n | input | 1 | Active-low asynchronous reset |
| sr_req | input | 1 | Level request to hold the device in self-refresh |
| ready | output | 1 | High when the device is idle and open for accesses |
| refresh_busy | output | 1 | High during a periodic refresh sequence |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cke | output | 1 | Clock enable |
| sd_addr | output | ROW_W | Address bus: bit 10 for precharge-all, mode word for LOAD MODE |
| sd_ba | output | BANK_W | Bank address, zero for all commands issued here |

## Verification
A wrong state or a miscounted wait timer shows up on the command pins as a command issued one or more cycles away from its expected cycle, or as a missing or extra command. The scoreboard notices the very next non-NOP command, so the error is visible within one sequence step (at most tRC+1 cycles during start-up). A faulty interval counter shifts the next precharge-all, which becomes visible one refresh interval after `ready` rises. A broken self-refresh hold shows up as CKE rising early, and the bench samples CKE in the last minimum-hold cycle to catch it.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [4:0] {
    ST_PWR_WAIT, ST_PRE, ST_PRE_WAIT, ST_REF, ST_REF_WAIT, ST_MRS, ST_MRS_WAIT,
    ST_IDLE, ST_RPRE, ST_RPRE_WAIT, ST_RREF, ST_RREF_WAIT,
    ST_SPRE, ST_SPRE_WAIT, ST_SR_ENTER, ST_SR_HOLD, ST_SR_EXIT
  } seq_state_e;

  // ceil(ns * hz / 1e9), never below two cycles
  function automatic int ns_to_cycles(input int ns, input longint hz);
    longint c;
    c = (longint'(ns) * hz + 64'd999_999_999) / 64'd1_000_000_000;
    if (c < 2) c = 2;
    return int'(c);
  endfunction

  function automatic int us_to_cycles(input int us, input longint hz);
    return int'((longint'(us) * hz + 64'd999_999) / 64'd1_000_000);
  endfunction

  function automatic int refresh_cycles(input int period_ms, input int rows, input longint hz);
    return int'((hz * longint'(period_ms)) / (64'd1000 * longint'(rows)));
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdr_wait_timer.sv
module sdr_wait_timer #(
  parameter int W       = 16,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= W'(RST_VAL);
    else if (load)         cnt <= load_val - W'(1);
    else if (cnt != '0)    cnt <= cnt - W'(1);
  end

  assign last = (cnt == '0);

  // R5
  load_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val) - W'(1)));

endmodule

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
  parameter int INTERVAL = 750
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic due
);
  localparam int CW = $clog2(INTERVAL + 1);
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + CW'(1);
  end

  assign due = run && (cnt == LAST);

  // R6
  due_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    due |=> (cnt == '0));

endmodule

// File: rtl/sdr_init_refresh_seq.sv
module sdr_init_refresh_seq
  import sdr_seq_pkg::*;
#(
  parameter longint CLK_HZ    = 48_000_000,
  parameter int     INIT_US   = 200,
  parameter int     INIT_REFS = 8,
  parameter int     ROW_W     = 12,
  parameter int     BANK_W    = 2,
  parameter int     T_RC_NS   = 65,
  parameter int     T_RP_NS   = 20,
  parameter int     T_RAS_NS  = 45,
  parameter int     T_XSR_NS  = 75,
  parameter int     T_MRD     = 2,
  parameter int     CAS_LAT   = 2,
  parameter int     BURST_LEN = 1,
  parameter int     REF_MS    = 64,
  parameter int     REF_ROWS  = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sr_req,
  output logic              ready,
  output logic              refresh_busy,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic              sd_cke,
  output logic [ROW_W-1:0]  sd_addr,
  output logic [BANK_W-1:0] sd_ba
);
  localparam int INIT_CYC = us_to_cycles(INIT_US, CLK_HZ);
  localparam int RP_CYC   = ns_to_cycles(T_RP_NS, CLK_HZ);
  localparam int RC_CYC   = ns_to_cycles(T_RC_NS, CLK_HZ);
  localparam int RAS_CYC  = ns_to_cycles(T_RAS_NS, CLK_HZ);
  localparam int XSR_CYC  = ns_to_cycles(T_XSR_NS, CLK_HZ);
  localparam int REF_INT  = refresh_cycles(REF_MS, REF_ROWS, CLK_HZ);
  localparam int MAX_WAIT = max2(max2(INIT_CYC, RC_CYC), max2(max2(RP_CYC, RAS_CYC), max2(XSR_CYC, T_MRD)));
  localparam int TW       = $clog2(MAX_WAIT + 1);
  localparam int RCW      = $clog2(INIT_REFS + 1);
  localparam int AP_BIT   = 10;
  localparam int BL_CODE  = $clog2(BURST_LEN);
  localparam logic [ROW_W-1:0] MODE_WORD =
    ROW_W'({CAS_LAT[2:0], 1'b0, BL_CODE[2:0]});

  seq_state_e state, state_nx;
  logic          tmr_load, tmr_last, ref_due, ref_pend, ref_run;
  logic [TW-1:0] tmr_val;
  logic [RCW-1:0] refs_left;
  sdr_cmd_e      cmd;

  sdr_wait_timer #(.W(TW), .RST_VAL(INIT_CYC - 1)) u_wait (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .last(tmr_last)
  );

  assign ref_run = (state == ST_IDLE) || (state == ST_RPRE) || (state == ST_RPRE_WAIT) ||
                   (state == ST_RREF) || (state == ST_RREF_WAIT);

  sdr_refresh_timer #(.INTERVAL(REF_INT)) u_ref (
    .clk(clk), .rst_n(rst_n), .run(ref_run), .due(ref_due)
  );

  always_comb begin
    state_nx = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_PWR_WAIT:  if (tmr_last) state_nx = ST_PRE;
      ST_PRE:       begin tmr_load = 1'b1; tmr_val = TW'(RP_CYC); state_nx = ST_PRE_WAIT; end
      ST_PRE_WAIT:  if (tmr_last) state_nx = ST_REF;
      ST_REF:       begin tmr_load = 1'b1; tmr_val = TW'(RC_CYC); state_nx = ST_REF_WAIT; end
      ST_REF_WAIT:  if (tmr_last) state_nx = (refs_left == '0) ? ST_MRS : ST_REF;
      ST_MRS:       begin tmr_load = 1'b1; tmr_val = TW'(T_MRD); state_nx = ST_MRS_WAIT; end
      ST_MRS_WAIT:  if (tmr_last) state_nx = ST_IDLE;
      ST_IDLE: begin
        if (ref_due || ref_pend) state_nx = ST_RPRE;
        else if (sr_req)         state_nx = ST_SPRE;
      end
      ST_RPRE:      begin tmr_load = 1'b1; tmr_val = TW'(RP_CYC); state_nx = ST_RPRE_WAIT; end
      ST_RPRE_WAIT: if (tmr_last) state_nx = ST_RREF;
      ST_RREF:      begin tmr_load = 1'b1; tmr_val = TW'(RC_CYC); state_nx = ST_RREF_WAIT; end
      ST_RREF_WAIT: if (tmr_last) state_nx = ST_IDLE;
      ST_SPRE:      begin tmr_load = 1'b1; tmr_val = TW'(RP_CYC); state_nx = ST_SPRE_WAIT; end
      ST_SPRE_WAIT: if (tmr_last) state_nx = ST_SR_ENTER;
      ST_SR_ENTER:  begin tmr_load = 1'b1; tmr_val = TW'(RAS_CYC); state_nx = ST_SR_HOLD; end
      ST_SR_HOLD: begin
        if (tmr_last && !sr_req) begin
          tmr_load = 1'b1; tmr_val = TW'(XSR_CYC); state_nx = ST_SR_EXIT;
        end
      end
      ST_SR_EXIT:   if (tmr_last) state_nx = ST_IDLE;
      default:      state_nx = ST_PWR_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_PWR_WAIT;
      refs_left <= RCW'(INIT_REFS);
      ref_pend  <= 1'b0;
    end else begin
      state <= state_nx;
      if (state == ST_REF) refs_left <= refs_left - RCW'(1);
      if (state == ST_RPRE)     ref_pend <= 1'b0;
      else if (ref_due)         ref_pend <= 1'b1;
    end
  end

  always_comb begin
    cmd     = CMD_NOP;
    sd_cke  = 1'b1;
    sd_addr = '0;
    sd_ba   = '0;
    unique case (state)
      ST_PRE, ST_RPRE, ST_SPRE: begin cmd = CMD_PRE; sd_addr[AP_BIT] = 1'b1; end
      ST_REF, ST_RREF:          cmd = CMD_REF;
      ST_MRS:                   begin cmd = CMD_MRS; sd_addr = MODE_WORD; end
      ST_SR_ENTER:              begin cmd = CMD_REF; sd_cke = 1'b0; end
      ST_SR_HOLD:               sd_cke = 1'b0;
      default:                  cmd = CMD_NOP;
    endcase
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign ready        = (state == ST_IDLE);
  assign refresh_busy = (state == ST_RPRE) || (state == ST_RPRE_WAIT) ||
                        (state == ST_RREF) || (state == ST_RREF_WAIT);

  // R4
  ready_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> sd_cke);
  // R7
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && refresh_busy));
  // R8
  sr_entry_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sd_cke) |-> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_REF));
  // R10
  sr_exit_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_cke) |-> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_NOP));
  // R3
  ref_then_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cke && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_REF) |=>
    ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_NOP));

endmodule

// File: tb/sdr_init_refresh_seq_bench.sv
`timescale 1ns/1ps
module sdr_init_refresh_seq_bench;
  localparam int INIT = 9600;
  localparam int TRP  = 2;
  localparam int TRC  = 4;
  localparam int TRAS = 3;
  localparam int TXSR = 4;
  localparam int TMRD = 2;
  localparam int RI   = 750;
  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

  typedef struct {
    int         at;
    logic [3:0] cmd;
    logic       cke;
    logic [11:0] addr;
    string      req;
  } ev_t;

  logic clk = 1'b0, rst_n = 1'b0, sr_req = 1'b0;
  logic ready, refresh_busy, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_cke;
  logic [11:0] sd_addr;
  logic [1:0]  sd_ba;
  int cyc = 0, total = 0, bad = 0;
  bit finished = 0;
  ev_t exp_q[$];

  always #2.5 clk = ~clk;

  sdr_init_refresh_seq u_sdr_init_refresh_seq (
    .clk(clk), .rst_n(rst_n), .sr_req(sr_req), .ready(ready), .refresh_busy(refresh_busy),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_cke(sd_cke), .sd_addr(sd_addr), .sd_ba(sd_ba)
  );

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", req, what, cyc, act, expv);
    end
  endtask

  task automatic push(input int at, input logic [3:0] c, input logic k, input logic [11:0] a, input string req);
    ev_t e;
    e.at = at; e.cmd = c; e.cke = k; e.addr = a; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // monitor: every non-NOP command is popped against the expected queue
  always @(negedge clk) begin
    if (rst_n && !finished && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} != NOP) begin
      if (exp_q.size() == 0) begin
        chk(0, "R12", "unexpected command", int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), int'(NOP));
      end else begin
        ev_t e;
        e = exp_q.pop_front();
        chk(cyc == e.at, e.req, "command cycle", cyc, e.at);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == e.cmd, e.req, "command code (R12)",
            int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), int'(e.cmd));
        chk(sd_cke == e.cke, e.req, "cke", int'(sd_cke), int'(e.cke));
        chk(sd_addr == e.addr && sd_ba == 2'b00, e.req, "address", int'({sd_ba, sd_addr}), int'(e.addr));
      end
    end
  end

  task automatic report;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200_000 * 5);
    chk(0, "R1", "watchdog expired", cyc, 13000);
    finished = 1;
    report();
  end

  initial begin
    int t, rdy, p;
    // expected start-up sequence (R2, R3, R4, R5)
    t = INIT;
    push(t, PRE, 1'b1, 12'h400, "R2");
    t = t + TRP + 1;
    for (int k = 0; k < 8; k++) begin
      push(t, REF, 1'b1, 12'h000, "R3");
      t = t + TRC + 1;
    end
    push(t, MRS, 1'b1, 12'h020, "R4");
    rdy = t + TMRD + 1;                              // 9646
    // first periodic refresh (R6, R7)
    p = rdy + RI;
    push(p, PRE, 1'b1, 12'h400, "R6");
    push(p + TRP + 1, REF, 1'b1, 12'h000, "R7");
    // self-refresh 1: request at 10500, release at 10600 (R8, R10)
    push(10501, PRE, 1'b1, 12'h400, "R8");
    push(10501 + TRP + 1, REF, 1'b0, 12'h000, "R8");
    p = 10601 + TXSR + RI;                           // restart of interval
    push(p, PRE, 1'b1, 12'h400, "R10");
    push(p + TRP + 1, REF, 1'b1, 12'h000, "R10");
    // self-refresh 2: request at 11400, released early (R9)
    push(11401, PRE, 1'b1, 12'h400, "R9");
    push(11404, REF, 1'b0, 12'h000, "R9");
    // refresh due at same time as request (R11)
    push(12162, PRE, 1'b1, 12'h400, "R11");
    push(12165, REF, 1'b1, 12'h000, "R11");
    push(12171, PRE, 1'b1, 12'h400, "R11");
    push(12174, REF, 1'b0, 12'h000, "R11");
    push(12955, PRE, 1'b1, 12'h400, "R6");
    push(12958, REF, 1'b1, 12'h000, "R6");

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state and power-up hold
    chk(sd_cke && !ready && !refresh_busy, "R1", "reset outputs", int'({sd_cke, ready, refresh_busy}), 4);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == NOP, "R1", "reset command", int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), int'(NOP));
    wait_cyc(INIT - 1);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == NOP && sd_cke && !ready, "R1", "still holding NOP", int'(ready), 0);
    wait_cyc(rdy - 1);
    chk(!ready, "R4", "ready before mode gap ends", int'(ready), 0);
    wait_cyc(rdy);
    chk(ready && sd_cke, "R4", "ready after mode load", int'(ready), 1);
    wait_cyc(rdy + RI);
    chk(refresh_busy && !ready, "R7", "busy at periodic precharge", int'(refresh_busy), 1);
    wait_cyc(rdy + RI + TRP + 1 + TRC);
    chk(refresh_busy, "R7", "busy in last refresh gap", int'(refresh_busy), 1);
    wait_cyc(rdy + RI + TRP + 1 + TRC + 1);
    chk(!refresh_busy && ready, "R7", "busy cleared", int'(refresh_busy), 0);
    wait_cyc(10500);
    sr_req = 1'b1;
    wait_cyc(10550);
    chk(!sd_cke && !ready, "R8", "cke low while held", int'(sd_cke), 0);
    wait_cyc(10600);
    sr_req = 1'b0;
    wait_cyc(10601);
    chk(sd_cke, "R10", "cke back high at exit", int'(sd_cke), 1);
    wait_cyc(10601 + TXSR - 1);
    chk(!ready, "R10", "ready low during exit wait", int'(ready), 0);
    wait_cyc(10601 + TXSR);
    chk(ready, "R10", "ready after exit wait", int'(ready), 1);
    wait_cyc(11400);
    sr_req = 1'b1;
    wait_cyc(11405);
    sr_req = 1'b0;
    wait_cyc(11404 + TRAS);
    chk(!sd_cke, "R9", "cke low for minimum hold", int'(sd_cke), 0);
    wait_cyc(11404 + TRAS + 1);
    chk(sd_cke, "R9", "cke high after minimum hold", int'(sd_cke), 1);
    wait_cyc(11412);
    chk(ready, "R10", "ready after short self-refresh", int'(ready), 1);
    wait_cyc(12161);
    sr_req = 1'b1;
    wait_cyc(12162);
    chk(refresh_busy && sd_cke, "R11", "refresh before self-refresh", int'(refresh_busy), 1);
    wait_cyc(12200);
    sr_req = 1'b0;
    wait_cyc(12205);
    chk(ready, "R10", "ready after third exit", int'(ready), 1);
    wait_cyc(13000);
    chk(exp_q.size() == 0, "R6", "missing commands", exp_q.size(), 0);
    finished = 1;
    report();
  end
endmodule